// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer With Float Disable

This block supervises a processor by watching one of its general-purpose output lines. Software toggles that line regularly. Every change of level, rising or falling, restarts an internal cycle counter. If the counter runs for a full timeout period without seeing a change, the active-low watchdog output drops. It stays low until the line moves again or the system reset clears the timer. The output is meant to drive a non-maskable interrupt. It can also be looped back into a manual reset input when a timeout should restart the system.

The same output also reports supply health. While the supply-good flag is low, the output is forced low whatever the timer holds. It comes back high in the same cycle that the supply recovers, with no reset stretch in between. The timer is held at zero while the upstream reset generator asserts reset, so the timeout period starts only when reset is released. The board can also mark the kick line as undriven (tri-stated). That flag switches the timeout off completely, and the output then reports only the supply condition.

The kick line and the undriven flag are asynchronous and pass through a synchroniser. The reset-generator state and the supply flag are taken to be synchronous to the block clock already. The timeout is set in clock cycles. At 100 MHz the default of 160,000,000 cycles gives 1.6 s, inside the allowed window of 1.0 s to 2.25 s.

Top module: `kick_watchdog`

## Requirements
- R1: While `rst_n` is low at a clock edge, the timer and its timeout state are cleared, so `wdog_n_o` equals `supply_ok_i` from the next cycle on.
- R2: With a good supply, reset released, the line driven and no kick edges, `wdog_n_o` falls exactly TIMEOUT_CYCLES clock edges after the last edge that cleared the timer, and never earlier.
- R3: A low-to-high change on `kick_i` clears the timer. The cleared state is visible at `wdog_n_o` after SYNC_STAGES+1 clock edges.
- R4: A high-to-low change on `kick_i` clears the timer in the same way as a rising change.
- R5: Once a timeout has occurred, `wdog_n_o` stays low until a kick edge, the reset-generator input or `rst_n` clears the timer.
- R6: While `rstgen_active_i` is high, the timer is held at zero and no timeout occurs. The full timeout period is counted from its release.
- R7: While the synchronised `kick_float_i` is high, the timer is held at zero and any earlier timeout is cleared, so `wdog_n_o` follows `supply_ok_i` alone. It takes effect SYNC_STAGES+1 edges after the flag rises. After the flag falls, counting restarts and a timeout follows TIMEOUT_CYCLES+SYNC_STAGES edges after the release.
- R8: While `supply_ok_i` is low, `wdog_n_o` is low in the same cycle, whether or not a timeout has occurred.
- R9: When `supply_ok_i` returns high, `wdog_n_o` goes high in the same cycle if no timeout is pending, and stays low if one is.
- R10: A kick edge that reaches the timer on the same clock edge as the terminal count wins. No timeout is flagged, and a new full period starts.
- R11: A kick pulse of two clock cycles, high then low, is caught as two edges. Pulses of that width, repeated more often than the timeout, keep `wdog_n_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of the block logic |
| kick_i | input | 1 | Toggle line from the processor, asynchronous |
| kick_float_i | input | 1 | High when the toggle line is undriven. Disables the timeout. Asynchronous |
| rstgen_active_i | input | 1 | High while the reset generator holds the system in reset. Synchronous |
| supply_ok_i | input | 1 | High while the supply is above its threshold. Synchronous |
| wdog_n_o | output | 1 | Active-low output: low on a timeout or a supply fault |

## Verification
The assertions check the timer's rules on every cycle. A timeout may rise only from the terminal count, and the counter never runs past it. A hold or a kick edge leaves the timer cleared on the next edge, and a timeout persists while nothing clears it. Other behaviour needs the bench's scenarios. These are the exact latency from a change on the asynchronous kick line to the output, the same-cycle supply override and release, the float disable over several timeout periods, and a kick landing on the terminal count. The same holds for two-cycle kick pulses and for a timeout measured from the release of reset or float.

// File: rtl/kwd_pkg.sv
// Shared helpers for the edge-kicked watchdog.
// Assumes: callers pass counts of at least 2.
package kwd_pkg;

    // Width needed to hold values 0 .. n-1, never less than one bit.
    function automatic int cnt_width(input int n);
        int w;
        w = $clog2(n);
        if (w < 1) w = 1;
        return w;
    endfunction

    // Default timeout: 1.6 s at a 100 MHz clock.
    localparam int DEFAULT_TIMEOUT = 160_000_000;

    // Default synchroniser depth for asynchronous inputs.
    localparam int DEFAULT_SYNC = 2;

endpackage

// File: rtl/kwd_sync.sv
// Multi-bit level synchroniser, one independent flop chain per bit.
// Does: moves slowly changing asynchronous levels into the clk domain.
// Assumes: bits are unrelated; no coherence between bits is needed.
module kwd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop captures the raw asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Later flops let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[LAST];
endmodule

// File: rtl/kwd_edge.sv
// Any-edge detector for one synchronised level.
// Does: pulses for one cycle after every rise or fall of level_i.
// Assumes: level_i is already in the clk domain; reset value matches
//          the synchroniser reset so no edge appears out of reset.
module kwd_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic edge_o
);
    logic prev_q;

    // Delayed copy of the level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level_i;
    end

    assign edge_o = level_i ^ prev_q;
endmodule

// File: rtl/kwd_timer.sv
// Timeout counter with hold and clear.
// Does: counts clock cycles since the last clear; flags expiry once the
//       count reaches TIMEOUT_CYCLES and keeps the flag until cleared.
// Assumes: TIMEOUT_CYCLES >= 2; hold_i and clear_i are synchronous.
module kwd_timer #(
    parameter int TIMEOUT_CYCLES = kwd_pkg::DEFAULT_TIMEOUT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic clear_i,
    output logic expired_o
);
    localparam int CW = kwd_pkg::cnt_width(TIMEOUT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          expired_q;

    // Count idle cycles; clear on reset, hold or kick (kick beats terminal).
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i || clear_i) begin
            cnt_q     <= '0;
            expired_q <= 1'b0;
        end else if (!expired_q) begin
            if (cnt_q == LAST) expired_q <= 1'b1;
            else               cnt_q     <= cnt_q + 1'b1;
        end
    end

    assign expired_o = expired_q;

    // R2
    expire_at_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired_q) |-> ($past(cnt_q) == LAST));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R6 R7
    hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (cnt_q == '0 && !expired_q));

    // R3 R4 R10
    kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0 && !expired_q));

    // R5
    expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_q && !hold_i && !clear_i) |=> expired_q);
endmodule

// File: rtl/kick_watchdog.sv
// Edge-kicked watchdog with float disable and low-supply indication.
// Does: synchronises the kick line and its undriven flag, turns any kick
//       edge into a timer clear, holds the timer during system reset or
//       while the line floats, and drives an active-low output that is
//       low on timeout or whenever the supply is bad.
// Assumes: rstgen_active_i and supply_ok_i are synchronous to clk.
module kick_watchdog #(
    parameter int TIMEOUT_CYCLES = kwd_pkg::DEFAULT_TIMEOUT,
    parameter int SYNC_STAGES    = kwd_pkg::DEFAULT_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic kick_float_i,
    input  logic rstgen_active_i,
    input  logic supply_ok_i,
    output logic wdog_n_o
);
    logic [1:0] async_bits;
    logic [1:0] sync_bits;
    logic       kick_s;
    logic       float_s;
    logic       kick_edge;
    logic       timer_hold;
    logic       expired;

    assign async_bits = {kick_float_i, kick_i};

    // Float flag resets to "undriven" so the timer starts disabled.
    kwd_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b10)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(async_bits),
        .sync_o (sync_bits)
    );

    assign kick_s  = sync_bits[0];
    assign float_s = sync_bits[1];

    kwd_edge #(
        .RST_VAL(1'b0)
    ) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(kick_s),
        .edge_o (kick_edge)
    );

    assign timer_hold = rstgen_active_i | float_s;

    kwd_timer #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (timer_hold),
        .clear_i  (kick_edge),
        .expired_o(expired)
    );

    // Supply path is combinational so fault and recovery act at once.
    assign wdog_n_o = supply_ok_i & ~expired;
endmodule

// File: tb/kick_watchdog_tb_top.sv
module kick_watchdog_tb_top;
    localparam int T = 20;
    localparam int S = 2;
    localparam int LAT = S + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick_i = 1'b0;
    logic kick_float_i = 1'b0;
    logic rstgen_active_i = 1'b1;
    logic supply_ok_i = 1'b1;
    logic wdog_n_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    kick_watchdog #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .kick_float_i(kick_float_i),
        .rstgen_active_i(rstgen_active_i), .supply_ok_i(supply_ok_i),
        .wdog_n_o(wdog_n_o)
    );

    // Driver side: push an expected output value for cycle cyc+off.
    task automatic expect_at(input int off, input logic val, input string tag);
        exp_t e;
        int i;
        e.at = cyc + off; e.val = val; e.tag = tag;
        i = 0;
        while (i < sb_q.size() && sb_q[i].at <= e.at) i++;
        sb_q.insert(i, e);
    endtask

    task automatic check_now(input logic val, input string tag);
        checks++;
        if (wdog_n_o !== val) begin
            fails++;
            $display("FAIL %s cyc=%0d wdog_n_o actual=%b expected=%b", tag, cyc, wdog_n_o, val);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: count edges, sample 2 ns after each, compare due items.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (e.at != cyc || wdog_n_o !== e.val) begin
                    fails++;
                    $display("FAIL %s cyc=%0d wdog_n_o actual=%b expected=%b", e.tag, cyc, wdog_n_o, e.val);
                end
            end
        end
    end

    initial begin
        for (int k = 0; k < 200000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired, run hung");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: block reset, supply good -> output high
        wait_cyc(3);
        check_now(1'b1, "R1");
        rst_n = 1'b1;
        // R6: held by reset generator, no timeout over a long wait
        expect_at(25, 1'b1, "R6");
        wait_cyc(30);
        // R2: release reset, timeout exactly T edges later
        rstgen_active_i = 1'b0;
        expect_at(T - 1, 1'b1, "R2");
        expect_at(T, 1'b0, "R2");
        wait_cyc(T + 2);
        // R5: stays low with no kick
        expect_at(5, 1'b0, "R5");
        wait_cyc(6);
        // R3: rising kick clears after LAT edges
        kick_i = 1'b1;
        expect_at(LAT - 1, 1'b0, "R5");
        expect_at(LAT, 1'b1, "R3");
        expect_at(LAT + T - 1, 1'b1, "R3");
        expect_at(LAT + T, 1'b0, "R3");
        wait_cyc(LAT + T + 2);
        // R4: falling kick clears
        kick_i = 1'b0;
        expect_at(LAT, 1'b1, "R4");
        expect_at(T, 1'b1, "R4");
        wait_cyc(T);
        // R10: kick edge reaches timer on the terminal-count edge
        kick_i = 1'b1;
        expect_at(LAT - 1, 1'b1, "R10");
        expect_at(LAT, 1'b1, "R10");
        expect_at(LAT + T - 1, 1'b1, "R10");
        expect_at(LAT + T, 1'b0, "R10");
        wait_cyc(T + 5);
        // R8/R9: supply fault while counting
        kick_i = 1'b0;
        wait_cyc(5);
        supply_ok_i = 1'b0;
        #1 check_now(1'b0, "R8");
        expect_at(1, 1'b0, "R8");
        wait_cyc(2);
        supply_ok_i = 1'b1;
        #1 check_now(1'b1, "R9");
        expect_at(1, 1'b1, "R9");
        wait_cyc(T + 2);
        // R9: recovery while timed out keeps output low
        check_now(1'b0, "R2");
        supply_ok_i = 1'b0;
        #1 check_now(1'b0, "R8");
        wait_cyc(1);
        supply_ok_i = 1'b1;
        #1 check_now(1'b0, "R9");
        wait_cyc(1);
        // R7: float disables and clears a pending timeout
        kick_float_i = 1'b1;
        expect_at(LAT - 1, 1'b0, "R7");
        expect_at(LAT, 1'b1, "R7");
        wait_cyc(LAT + 2);
        kick_i = 1'b1;
        wait_cyc(2);
        kick_i = 1'b0;
        expect_at(3 * T, 1'b1, "R7");
        wait_cyc(3 * T);
        supply_ok_i = 1'b0;
        #1 check_now(1'b0, "R7");
        wait_cyc(1);
        supply_ok_i = 1'b1;
        #1 check_now(1'b1, "R7");
        wait_cyc(1);
        kick_float_i = 1'b0;
        expect_at(S + T - 1, 1'b1, "R7");
        expect_at(S + T, 1'b0, "R7");
        wait_cyc(S + T + 2);
        // R11: two-cycle pulses every 10 cycles keep it alive
        for (int i = 0; i < 8; i++) begin
            kick_i = 1'b1;
            if (i > 0) expect_at(1, 1'b1, "R11");
            wait_cyc(2);
            kick_i = 1'b0;
            wait_cyc(8);
        end
        expect_at(LAT + T - 8 - 1, 1'b1, "R11");
        expect_at(LAT + T - 8, 1'b0, "R11");
        wait_cyc(T);
        // R6: reset generator clears a timeout, period counts from release
        rstgen_active_i = 1'b1;
        expect_at(1, 1'b1, "R6");
        wait_cyc(10);
        rstgen_active_i = 1'b0;
        expect_at(T - 1, 1'b1, "R6");
        expect_at(T, 1'b0, "R6");
        wait_cyc(T + 2);
        // R1: block reset clears a timeout
        rst_n = 1'b0;
        rstgen_active_i = 1'b1;
        expect_at(1, 1'b1, "R1");
        wait_cyc(4);
        if (sb_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard actual=%0d expected=0 items left", sb_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule